// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This unit carries out one atomic memory operation at a time for a 64-bit register machine. A request gives the 8-bit opcode, the 32-bit immediate, the base register value, a signed 16-bit displacement, the source register index and value, and the value of register 0. The unit checks that the encoding names an atomic operation. It then requests a memory lock and waits for the grant. Under the lock it reads the target word, computes the update, writes the result back when one is due, and drops the lock.

The immediate, not the opcode, picks the operation. The operations are add, and, or, xor, exchange and compare-exchange. Bit 0 of the immediate asks for the old memory value to be returned. At the end of the operation the unit raises a one-cycle completion pulse. With that pulse it gives any register update as an index and a 64-bit value, which the surrounding pipeline applies to its register file.

Top module: `amo_rmw_unit`

## Requirements
- R1: Only opcode 0xc3 (word, 4 bytes) and opcode 0xdb (doubleword, 8 bytes) are accepted. Any other opcode, including the byte form 0xd3, the halfword form 0xcb and the wrong class 0xc2, ends in a `done` pulse with `err`=1 and `wb_en`=0. In that case there is no lock request and no memory access.
- R2: The memory address is `dst_val` plus the sign-extended `offset`, computed modulo 2^64.
- R3: The lock is requested in the cycle after the request is accepted and held until the write cycle. The read occurs only while the grant is present. The lock is released in the `done` cycle.
- R4: The immediates 0x00 (add), 0x50 (and), 0x40 (or) and 0xa0 (xor) write the memory value combined with `src_val` back to the same address, with no register update.
- R5: The immediates 0x01, 0x51, 0x41 and 0xa1 perform the same updates as R4. They also return the old memory value to register `src_idx`.
- R6: Immediate 0xe1 (exchange) writes `src_val` to memory and returns the old memory value to register `src_idx`.
- R7: Immediate 0xf1 (compare-exchange) writes `src_val` only when the memory value equals `r0_val`. On a mismatch there is no write. In both cases the old value is returned to register index 0.
- R8: Word operations use only the low 32 bits for the operands and for the compare. The write is a word write (`mem_dw`=0) whose upper 32 data bits are 0. Every returned value is zero-extended to 64 bits.
- R9: An immediate other than those listed in R4 to R7 ends in a `done` pulse with `err`=1, with no register update and no memory access.
- R10: `done` lasts exactly one cycle. `wb_en` is raised only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted while idle |
| opcode | input | 8 | Instruction opcode byte |
| imm | input | 32 | Immediate, selects the operation |
| dst_val | input | 64 | Base address register value |
| offset | input | 16 | Signed displacement |
| src_idx | input | 4 | Source register index |
| src_val | input | 64 | Source register value |
| r0_val | input | 64 | Register 0 value (compare operand) |
| busy | output | 1 | Operation in progress |
| mem_lock_req | output | 1 | Memory lock request |
| mem_lock_gnt | input | 1 | Memory lock grant |
| mem_rd_en | output | 1 | Read strobe; data returns on the next cycle |
| mem_wr_en | output | 1 | Write strobe |
| mem_dw | output | 1 | 1: 8-byte access, 0: low 4 bytes only |
| mem_addr | output | 64 | Byte address |
| mem_wr_data | output | 64 | Write data |
| mem_rd_data | input | 64 | Read data |
| done | output | 1 | Completion pulse |
| err | output | 1 | Illegal encoding, valid with done |
| wb_en | output | 1 | Register update valid |
| wb_idx | output | 4 | Register index to update |
| wb_data | output | 64 | Register update value |

## Verification
Every legal immediate is run at both sizes against three operand patterns. One pattern has the sign bits of both halves set, so that a carry into bit 32 and nonzero upper halves show whether the word form truly confines itself to the low half and leaves the upper half of memory intact. Compare-exchange is run with a match and with a mismatch. In the word match case the upper halves of memory and `r0_val` differ on purpose, so a full 64-bit compare would wrongly miss. Negative and positive displacements test the sign extension. Bad opcodes and immediates are checked for the absence of any lock or memory activity.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    AMO_ADD  = 3'd0,
    AMO_AND  = 3'd1,
    AMO_OR   = 3'd2,
    AMO_XOR  = 3'd3,
    AMO_XCHG = 3'd4,
    AMO_CMPX = 3'd5
  } amo_op_e;

  typedef struct packed {
    amo_op_e op;
    logic    ret_old;
    logic    dw;
    logic    legal;
  } amo_dec_t;

  localparam logic [7:0] OPC_ATOM_W  = 8'hc3;
  localparam logic [7:0] OPC_ATOM_DW = 8'hdb;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
#(
  parameter int IMM_W = 32
) (
  input  logic [7:0]       opcode,
  input  logic [IMM_W-1:0] imm,
  output amo_dec_t         dec
);
  localparam logic [IMM_W-1:0] IMM_ADD  = IMM_W'(8'h00);
  localparam logic [IMM_W-1:0] IMM_AND  = IMM_W'(8'h50);
  localparam logic [IMM_W-1:0] IMM_OR   = IMM_W'(8'h40);
  localparam logic [IMM_W-1:0] IMM_XOR  = IMM_W'(8'ha0);
  localparam logic [IMM_W-1:0] IMM_XCHG = IMM_W'(8'he1);
  localparam logic [IMM_W-1:0] IMM_CMPX = IMM_W'(8'hf1);
  localparam logic [IMM_W-1:0] FETCH    = IMM_W'(1);

  logic opc_ok;
  logic imm_ok;

  always_comb begin
    opc_ok      = (opcode == OPC_ATOM_W) || (opcode == OPC_ATOM_DW);
    imm_ok      = 1'b1;
    dec.op      = AMO_ADD;
    dec.ret_old = imm[0];
    dec.dw      = (opcode == OPC_ATOM_DW);
    unique case (imm & ~FETCH)
      IMM_ADD: dec.op = AMO_ADD;
      IMM_AND: dec.op = AMO_AND;
      IMM_OR:  dec.op = AMO_OR;
      IMM_XOR: dec.op = AMO_XOR;
      default: imm_ok = 1'b0;
    endcase
    if (imm == IMM_XCHG) begin
      dec.op      = AMO_XCHG;
      dec.ret_old = 1'b1;
      imm_ok      = 1'b1;
    end else if (imm == IMM_CMPX) begin
      dec.op      = AMO_CMPX;
      dec.ret_old = 1'b1;
      imm_ok      = 1'b1;
    end
    dec.legal = opc_ok && imm_ok;
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_op_e         op,
  input  logic            dw,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] cmp_val,
  output logic [XLEN-1:0] new_val,
  output logic [XLEN-1:0] ret_val,
  output logic            need_write
);
  localparam int HW = XLEN / 2;

  logic [XLEN-1:0] res;
  logic            cmp_eq;

  always_comb begin
    unique case (op)
      AMO_ADD:  res = old_val + src_val;
      AMO_AND:  res = old_val & src_val;
      AMO_OR:   res = old_val | src_val;
      AMO_XOR:  res = old_val ^ src_val;
      AMO_XCHG: res = src_val;
      AMO_CMPX: res = src_val;
      default:  res = old_val;
    endcase
    cmp_eq     = dw ? (old_val == cmp_val) : (old_val[HW-1:0] == cmp_val[HW-1:0]);
    need_write = (op != AMO_CMPX) || cmp_eq;
    new_val    = dw ? res : {{HW{1'b0}}, res[HW-1:0]};
    ret_val    = dw ? old_val : {{HW{1'b0}}, old_val[HW-1:0]};
  end
endmodule

// File: rtl/amo_ctrl.sv
module amo_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic legal,
  input  logic gnt,
  input  logic need_write,
  output logic accept,
  output logic lock_req,
  output logic rd_en,
  output logic cap_en,
  output logic wr_en,
  output logic done,
  output logic err,
  output logic busy
);
  typedef enum logic [2:0] {
    S_IDLE, S_FAULT, S_LOCK, S_READ, S_CAPT, S_STORE, S_FIN
  } st_e;

  st_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    accept  = 1'b0;
    unique case (state_q)
      S_IDLE: if (start) begin
        accept  = 1'b1;
        state_d = legal ? S_LOCK : S_FAULT;
      end
      S_LOCK:  if (gnt) state_d = S_READ;
      S_READ:  state_d = S_CAPT;
      S_CAPT:  state_d = S_STORE;
      S_STORE: state_d = S_FIN;
      S_FIN:   state_d = S_IDLE;
      S_FAULT: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    lock_req = (state_q == S_LOCK) || (state_q == S_READ) ||
               (state_q == S_CAPT) || (state_q == S_STORE);
    rd_en    = (state_q == S_READ);
    cap_en   = (state_q == S_CAPT);
    wr_en    = (state_q == S_STORE) && need_write;
    done     = (state_q == S_FIN) || (state_q == S_FAULT);
    err      = (state_q == S_FAULT);
    busy     = (state_q != S_IDLE);
  end

  // R3
  rd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (lock_req && gnt));
  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en, 2));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R1
  fault_nolock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!lock_req && !rd_en && !wr_en));
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int IMM_W = 32,
  parameter int OFF_W = 16,
  parameter int RIDX  = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      opcode,
  input  logic [IMM_W-1:0] imm,
  input  logic [XLEN-1:0] dst_val,
  input  logic [OFF_W-1:0] offset,
  input  logic [RIDX-1:0] src_idx,
  input  logic [XLEN-1:0] src_val,
  input  logic [XLEN-1:0] r0_val,
  output logic            busy,
  output logic            mem_lock_req,
  input  logic            mem_lock_gnt,
  output logic            mem_rd_en,
  output logic            mem_wr_en,
  output logic            mem_dw,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wr_data,
  input  logic [XLEN-1:0] mem_rd_data,
  output logic            done,
  output logic            err,
  output logic            wb_en,
  output logic [RIDX-1:0] wb_idx,
  output logic [XLEN-1:0] wb_data
);
  localparam int HW = XLEN / 2;

  amo_dec_t        dec_d, dec_q;
  logic [XLEN-1:0] addr_q, src_q, r0_q, old_q;
  logic [RIDX-1:0] sidx_q;
  logic            accept, cap_en, need_write;
  logic [XLEN-1:0] new_val, ret_val;

  amo_decode #(.IMM_W(IMM_W)) u_dec (
    .opcode (opcode),
    .imm    (imm),
    .dec    (dec_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q  <= '0;
      addr_q <= '0;
      src_q  <= '0;
      r0_q   <= '0;
      sidx_q <= '0;
    end else if (accept) begin
      dec_q  <= dec_d;
      addr_q <= dst_val + {{(XLEN-OFF_W){offset[OFF_W-1]}}, offset};
      src_q  <= src_val;
      r0_q   <= r0_val;
      sidx_q <= src_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      old_q <= '0;
    else if (cap_en) old_q <= mem_rd_data;
  end

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op         (dec_q.op),
    .dw         (dec_q.dw),
    .old_val    (old_q),
    .src_val    (src_q),
    .cmp_val    (r0_q),
    .new_val    (new_val),
    .ret_val    (ret_val),
    .need_write (need_write)
  );

  amo_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .legal      (dec_d.legal),
    .gnt        (mem_lock_gnt),
    .need_write (need_write),
    .accept     (accept),
    .lock_req   (mem_lock_req),
    .rd_en      (mem_rd_en),
    .cap_en     (cap_en),
    .wr_en      (mem_wr_en),
    .done       (done),
    .err        (err),
    .busy       (busy)
  );

  always_comb begin
    mem_addr    = addr_q;
    mem_dw      = dec_q.dw;
    mem_wr_data = new_val;
    wb_en       = done && !err && dec_q.ret_old;
    wb_idx      = (dec_q.op == AMO_CMPX) ? '0 : sidx_q;
    wb_data     = ret_val;
  end

  // R10
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && !err));
  // R8
  word_wr_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_dw) |-> (mem_wr_data[XLEN-1:HW] == '0));
  // R8
  word_wb_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_en && !mem_dw) |-> (wb_data[XLEN-1:HW] == '0));
  // R2
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_lock_req && $past(mem_lock_req)) |-> $stable(mem_addr));
endmodule

// File: tb/amo_rmw_unit_tb_top.sv
module amo_rmw_unit_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        start = 0;
  logic [7:0]  opcode = 0;
  logic [31:0] imm = 0;
  logic [63:0] dst_val = 0, src_val = 0, r0_val = 0;
  logic [15:0] offset = 0;
  logic [3:0]  src_idx = 0;
  logic        busy, lock_req, rd_en, wr_en, mem_dw, done, err, wb_en;
  logic        gnt = 0;
  logic [63:0] mem_addr, wr_data, wb_data;
  logic [63:0] rd_data = 0;
  logic [3:0]  wb_idx;

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, lock_cnt = 0, nogrant_rd = 0;
  logic [63:0] rd_addr_seen = 0;
  logic [63:0] mem [8];

  always #2.5 clk = ~clk;

  amo_rmw_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .imm(imm),
    .dst_val(dst_val), .offset(offset), .src_idx(src_idx), .src_val(src_val),
    .r0_val(r0_val), .busy(busy), .mem_lock_req(lock_req), .mem_lock_gnt(gnt),
    .mem_rd_en(rd_en), .mem_wr_en(wr_en), .mem_dw(mem_dw), .mem_addr(mem_addr),
    .mem_wr_data(wr_data), .mem_rd_data(rd_data), .done(done), .err(err),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  always @(posedge clk) begin
    gnt <= lock_req;
    if (lock_req) lock_cnt <= lock_cnt + 1;
    if (rd_en) begin
      rd_cnt <= rd_cnt + 1;
      rd_addr_seen <= mem_addr;
      rd_data <= mem[mem_addr[5:3]];
      if (!gnt) nogrant_rd <= nogrant_rd + 1;
    end
    if (wr_en) begin
      wr_cnt <= wr_cnt + 1;
      if (mem_dw) mem[mem_addr[5:3]] <= wr_data;
      else        mem[mem_addr[5:3]][31:0] <= wr_data[31:0];
    end
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [31:0] im, input logic [63:0] dv,
                        input logic [15:0] off, input logic [3:0] si, input logic [63:0] sv,
                        input logic [63:0] r0, input logic [63:0] mold, input bit bad);
    logic [63:0] addr, a, s, r, res, exp_mem, exp_wb;
    bit dw, wr, wbe, cm;
    int waits;
    addr = dv + {{48{off[15]}}, off};
    dw = (opc == 8'hdb);
    a = dw ? mold : {32'h0, mold[31:0]};
    s = dw ? sv : {32'h0, sv[31:0]};
    r = dw ? r0 : {32'h0, r0[31:0]};
    wr = 1; cm = 0;
    case (im)
      32'h00, 32'h01: res = a + s;
      32'h50, 32'h51: res = a & s;
      32'h40, 32'h41: res = a | s;
      32'ha0, 32'ha1: res = a ^ s;
      32'he1:         res = s;
      default: begin res = s; cm = 1; wr = (a == r); end
    endcase
    if (!dw) res = {32'h0, res[31:0]};
    exp_mem = dw ? res : {mold[63:32], res[31:0]};
    if (!wr) exp_mem = mold;
    wbe = im[0];
    exp_wb = a;
    @(negedge clk);
    mem[addr[5:3]] = mold;
    opcode = opc; imm = im; dst_val = dv; offset = off; src_idx = si;
    src_val = sv; r0_val = r0; start = 1;
    rd_cnt = 0; wr_cnt = 0; lock_cnt = 0;
    @(negedge clk);
    start = 0;
    waits = 0;
    while (!done && waits < 20) begin @(negedge clk); waits++; end
    if (bad) begin
      chk(err == 1, "R1/R9 err", {63'h0, err}, 64'h1);
      chk(wb_en == 0 && rd_cnt == 0 && wr_cnt == 0 && lock_cnt == 0 && !lock_req,
          "R1/R9 no access", {32'(rd_cnt), 32'(lock_cnt)}, 64'h0);
    end else begin
      chk(err == 0, "R1 legal", {63'h0, err}, 64'h0);
      chk(rd_addr_seen == addr, "R2 address", rd_addr_seen, addr);
      chk(!lock_req && nogrant_rd == 0 && lock_cnt > 0, "R3 lock", {63'h0, lock_req}, 64'h0);
      chk(wb_en == wbe, cm ? "R7 wb_en" : (im == 32'he1 ? "R6 wb_en" : (wbe ? "R5 wb_en" : "R4 wb_en")),
          {63'h0, wb_en}, {63'h0, wbe});
      if (wbe) begin
        chk(wb_idx == (cm ? 4'd0 : si), "R7 R5 wb_idx", {60'h0, wb_idx}, {60'h0, cm ? 4'd0 : si});
        chk(wb_data == exp_wb, dw ? "R5 wb_data" : "R8 wb_data", wb_data, exp_wb);
      end
      chk(wr_cnt == (wr ? 1 : 0), "R7 write count", 64'(wr_cnt), {63'h0, wr});
      chk(mem[addr[5:3]] == exp_mem, dw ? "R4 memory" : "R8 memory", mem[addr[5:3]], exp_mem);
    end
    @(negedge clk);
    chk(!done, "R10 done pulse", {63'h0, done}, 64'h0);
  endtask

  logic [31:0] imms [10] = '{32'h00, 32'h01, 32'h50, 32'h51, 32'h40, 32'h41,
                            32'ha0, 32'ha1, 32'he1, 32'hf1};
  logic [63:0] pm [3] = '{64'hffff_ffff_8000_0001, 64'h0123_4567_89ab_cdef, 64'h0};
  logic [63:0] ps [3] = '{64'h0000_0001_7fff_ffff, 64'hf0f0_0000_ffff_0000, 64'h8000_0000_0000_0001};

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 0;
    repeat (3) @(negedge clk);
    chk(!done && !lock_req && !busy && !rd_en && !wr_en, "R10 reset state", {63'h0, busy}, 64'h0);
    rst_n = 1;
    for (int k = 0; k < 10; k++)
      for (int z = 0; z < 2; z++)
        for (int p = 0; p < 3; p++) begin
          logic [63:0] r0;
          r0 = 64'h5555_aaaa_1234_5678;
          if (imms[k] == 32'hf1 && p != 1) r0 = (p == 0) ? {~pm[p][63:32], pm[p][31:0]} : pm[p];
          if (imms[k] == 32'hf1 && p == 0 && z == 1) r0 = pm[p];
          run_op(z ? 8'hdb : 8'hc3, imms[k], 64'h1000 + 64'(p * 8), (p == 1) ? 16'hfff8 : 16'h0010,
                 4'(k + 1), ps[p], r0, pm[p], 0);
        end
    // R7 word mismatch in low half with equal upper halves
    run_op(8'hc3, 32'hf1, 64'h2000, 16'h0, 4'd3, 64'h9, 64'hffff_0000_0000_0001, 64'hffff_0000_0000_0002, 0);
    // R1 illegal sizes and class
    run_op(8'hd3, 32'h0, 64'h2000, 16'h0, 4'd3, 64'h9, 64'h0, 64'h5, 1);
    run_op(8'hcb, 32'h1, 64'h2000, 16'h0, 4'd3, 64'h9, 64'h0, 64'h5, 1);
    run_op(8'hc2, 32'h0, 64'h2000, 16'h0, 4'd3, 64'h9, 64'h0, 64'h5, 1);
    // R9 illegal immediates
    run_op(8'hdb, 32'h10, 64'h2000, 16'h0, 4'd3, 64'h9, 64'h0, 64'h5, 1);
    run_op(8'hc3, 32'he0, 64'h2000, 16'h0, 4'd3, 64'h9, 64'h0, 64'h5, 1);
    run_op(8'hdb, 32'h100, 64'h2000, 16'h0, 4'd3, 64'h9, 64'h0, 64'h5, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule